// File: doc/BRIEF.md
# Basic Interval Timer with Wake Stabilization

This block is a free-running interval timer for a small microcontroller. A free-running binary divider on the system clock offers four tap rates. A small up-counter advances at the selected rate. Each time the counter wraps, the block raises an interrupt request flag. Software controls it through a 4-bit write-only mode word. The three low bits choose the rate. The top bit is a restart command that is never stored: writing it as 1 clears the counter and the flag in the same step. No setting can halt the counter.

The counter wrap also times the wait for the oscillator to settle. After a system reset, and again when stop mode is released, the `stable` output stays low until the next wrap. After a system reset this wait runs at a fixed boot rate. The software rate selection has no effect on the boot wait. With the default parameters the overflow interval runs from 2^13 to 2^20 system clocks, and the boot wait is close to 2^17 clocks.

Top module: `interval_tmr`

## Requirements
- R1: Synchronous reset sets `cnt` to 0, `irq` to 0 and `stable` to 0, and sets the rate code to 000. After the boot wait, the overflow interval is therefore the slowest one.
- R2: A restart command clears `cnt` and `irq` at the next clock edge. A restart command is either `mode_we` with `mode_wdata[3]`=1, or `bit_we` with `bit_wdata`=1. The restart bit is not retained, so counting resumes at once. `bit_we` with `bit_wdata`=0 changes nothing, and `mode_we` with `mode_wdata[3]`=0 does not restart.
- R3: The counter never stops. Under every rate code the counter advances by one on each tap tick. The counter changes only on a tick, a restart or a stop release.
- R4: The rate code is `mode_wdata[2:0]`. The tap bit is chosen as follows: 000 selects TAP_A, 011 selects TAP_B, 101 selects TAP_C and 111 selects TAP_D. Tap bit T gives one count every 2^(T+1) clocks, so the overflow interval is 2^(CNT_W+T+1) clocks. With the defaults the intervals are 2^20, 2^17, 2^15 and 2^13 clocks.
- R5: The rate codes 001, 010, 100 and 110 behave exactly like 000.
- R6: `irq` is set on the edge where the counter wraps from all ones to zero. It stays set until a restart command or an `irq_clr` pulse. A wrap takes priority over `irq_clr` in the same cycle.
- R7: Writing a new rate code without the restart bit leaves `cnt` unchanged. The new rate governs all later ticks.
- R8: `stop_enter` drops `stable` at the next edge. `stop_release` clears `cnt` and keeps `stable` low. `stable` rises on the edge of the first wrap that follows, together with `irq`.
- R9: After reset, the counter runs at tap TAP_BOOT whatever rate code is written. `stable` rises on the first wrap, roughly 2^(CNT_W+TAP_BOOT+1) clocks after reset. The selected rate applies from then on.
- R10: A restart command takes priority over a tick in the same cycle, so `cnt` is 0 after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_we | input | 1 | Write strobe for the whole mode word |
| mode_wdata | input | 4 | Mode word: [3] restart, [2:0] rate code |
| bit_we | input | 1 | Write strobe for the restart bit alone |
| bit_wdata | input | 1 | Value written to the restart bit |
| irq_clr | input | 1 | Clears the interrupt request flag |
| stop_enter | input | 1 | Pulse when stop mode is entered |
| stop_release | input | 1 | Pulse when stop mode is released |
| cnt | output | CNT_W | Current counter value |
| irq | output | 1 | Interrupt request flag |
| stable | output | 1 | Clock considered stable after a wait |

## Verification
The assertions check the following on every cycle:
- a restart, including one that collides with a tick, empties the counter and the flag;
- a wrap always sets the flag, and the flag holds until it is cleared;
- the counter stays frozen between ticks;
- ticks are never adjacent;
- `stable` rises only on a wrap, and falls after a stop entry.

Only the bench scenarios can show that each rate code, including the unlisted codes, yields the exact overflow interval. They also show that a rate change keeps the count, that the boot wait ignores the software selection, and that the wait after a stop release lasts one full interval.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  typedef enum logic [2:0] {
    RT_A    = 3'd0,
    RT_B    = 3'd1,
    RT_C    = 3'd2,
    RT_D    = 3'd3,
    RT_BOOT = 3'd4
  } rate_e;

  function automatic rate_e decode_rate(input logic [2:0] code);
    case (code)
      3'b011:  return RT_B;
      3'b101:  return RT_C;
      3'b111:  return RT_D;
      default: return RT_A;
    endcase
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction
endpackage

// File: rtl/tmr_mode_reg.sv
module tmr_mode_reg (
  input  logic               clk,
  input  logic               rst,
  input  logic               mode_we,
  input  logic [3:0]         mode_wdata,
  input  logic               bit_we,
  input  logic               bit_wdata,
  output tmr_pkg::rate_e     rate,
  output logic               restart
);
  logic [2:0] sel_q;

  always_ff @(posedge clk) begin
    if (rst)          sel_q <= 3'b000;
    else if (mode_we) sel_q <= mode_wdata[2:0];
  end

  // restart bit is a command, never stored
  always_comb begin
    restart = (mode_we && mode_wdata[3]) || (bit_we && bit_wdata);
    rate    = tmr_pkg::decode_rate(sel_q);
  end

  AST_SEL_KEEP: assert property (@(posedge clk) disable iff (rst)
    !mode_we |=> $stable(sel_q)); // R7
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int TAP_A    = 11,
  parameter int TAP_B    = 8,
  parameter int TAP_C    = 6,
  parameter int TAP_D    = 4,
  parameter int TAP_BOOT = 8
) (
  input  logic           clk,
  input  logic           rst,
  input  tmr_pkg::rate_e rate,
  input  logic           boot,
  output logic           tick
);
  localparam int PRE_W = tmr_pkg::max_of(tmr_pkg::max_of(tmr_pkg::max_of(TAP_A, TAP_B),
                         tmr_pkg::max_of(TAP_C, TAP_D)), TAP_BOOT) + 1;
  localparam int NTAP = 5;
  localparam int TAPS [NTAP] = '{TAP_A, TAP_B, TAP_C, TAP_D, TAP_BOOT};

  logic [PRE_W-1:0] div;
  logic [NTAP-1:0]  tap_hit;

  always_ff @(posedge clk) begin
    if (rst) div <= '0;
    else     div <= div + 1'b1;
  end

  // a tap ticks on the cycle before its bit rises
  for (genvar g = 0; g < NTAP; g++) begin : g_tap
    localparam int T = TAPS[g];
    assign tap_hit[g] = (div[T:0] == {1'b0, {T{1'b1}}});
  end

  always_comb begin
    if (boot) tick = tap_hit[NTAP-1];
    else      tick = tap_hit[rate];
  end

  AST_TICK_SPACED: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick); // R4
endmodule

// File: rtl/tmr_count.sv
module tmr_count #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             restart,
  input  logic             stop_release,
  input  logic             irq_clr,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             wrap
);
  always_comb wrap = tick && (cnt == '1) && !restart && !stop_release;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      if (restart || stop_release) cnt <= '0;
      else if (tick)               cnt <= cnt + 1'b1;

      if (restart)      irq <= 1'b0;
      else if (wrap)    irq <= 1'b1;
      else if (irq_clr) irq <= 1'b0;
    end
  end

  AST_RESTART_CLR: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt == '0 && !irq)); // R2
  AST_RESTART_WINS: assert property (@(posedge clk) disable iff (rst)
    (restart && tick) |=> (cnt == '0)); // R10
  AST_WRAP_IRQ: assert property (@(posedge clk) disable iff (rst)
    (tick && cnt == '1 && !restart && !stop_release) |=> irq); // R6
  AST_IRQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (irq && !restart && !irq_clr) |=> irq); // R6
  AST_CNT_FROZEN: assert property (@(posedge clk) disable iff (rst)
    (!tick && !restart && !stop_release) |=> $stable(cnt)); // R3
  AST_RELEASE_CLR: assert property (@(posedge clk) disable iff (rst)
    stop_release |=> (cnt == '0)); // R8
endmodule

// File: rtl/tmr_wake.sv
module tmr_wake (
  input  logic clk,
  input  logic rst,
  input  logic stop_enter,
  input  logic stop_release,
  input  logic wrap,
  output logic stable,
  output logic boot
);
  logic waiting;

  always_ff @(posedge clk) begin
    if (rst) begin
      stable  <= 1'b0;
      waiting <= 1'b1;
      boot    <= 1'b1;
    end else if (stop_enter) begin
      stable  <= 1'b0;
      waiting <= 1'b0;
      boot    <= 1'b0;
    end else if (stop_release) begin
      stable  <= 1'b0;
      waiting <= 1'b1;
      boot    <= 1'b0;
    end else if (wrap && waiting) begin
      stable  <= 1'b1;
      waiting <= 1'b0;
      boot    <= 1'b0;
    end
  end

  AST_STOP_DROP: assert property (@(posedge clk) disable iff (rst)
    stop_enter |=> !stable); // R8
  AST_STABLE_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(stable) |-> $past(wrap)); // R8
endmodule

// File: rtl/interval_tmr.sv
module interval_tmr #(
  parameter int CNT_W    = 8,
  parameter int TAP_A    = 11,
  parameter int TAP_B    = 8,
  parameter int TAP_C    = 6,
  parameter int TAP_D    = 4,
  parameter int TAP_BOOT = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             mode_we,
  input  logic [3:0]       mode_wdata,
  input  logic             bit_we,
  input  logic             bit_wdata,
  input  logic             irq_clr,
  input  logic             stop_enter,
  input  logic             stop_release,
  output logic [CNT_W-1:0] cnt,
  output logic             irq,
  output logic             stable
);
  tmr_pkg::rate_e rate;
  logic restart, tick, wrap, boot;

  tmr_mode_reg i_mode (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .bit_we(bit_we), .bit_wdata(bit_wdata), .rate(rate), .restart(restart)
  );

  tmr_prescaler #(
    .TAP_A(TAP_A), .TAP_B(TAP_B), .TAP_C(TAP_C), .TAP_D(TAP_D), .TAP_BOOT(TAP_BOOT)
  ) i_pre (
    .clk(clk), .rst(rst), .rate(rate), .boot(boot), .tick(tick)
  );

  tmr_count #(.CNT_W(CNT_W)) i_cnt (
    .clk(clk), .rst(rst), .tick(tick), .restart(restart),
    .stop_release(stop_release), .irq_clr(irq_clr),
    .cnt(cnt), .irq(irq), .wrap(wrap)
  );

  tmr_wake i_wake (
    .clk(clk), .rst(rst), .stop_enter(stop_enter), .stop_release(stop_release),
    .wrap(wrap), .stable(stable), .boot(boot)
  );
endmodule

// File: tb/test_interval_tmr.sv
module test_interval_tmr;
  localparam int CW = 4;
  localparam int TA = 7, TB = 5, TC = 3, TD = 1, TBOOT = 5;

  logic clk = 0, rst = 1;
  logic mode_we = 0, bit_we = 0, bit_wdata = 0, irq_clr = 0;
  logic stop_enter = 0, stop_release = 0;
  logic [3:0] mode_wdata = 0;
  logic [CW-1:0] cnt;
  logic irq, stable;
  int cyc = 0;
  int n_tests = 0, n_fail = 0;
  bit done = 0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  interval_tmr #(.CNT_W(CW), .TAP_A(TA), .TAP_B(TB), .TAP_C(TC), .TAP_D(TD),
                 .TAP_BOOT(TBOOT)) i_interval_tmr (
    .clk(clk), .rst(rst), .mode_we(mode_we), .mode_wdata(mode_wdata),
    .bit_we(bit_we), .bit_wdata(bit_wdata), .irq_clr(irq_clr),
    .stop_enter(stop_enter), .stop_release(stop_release),
    .cnt(cnt), .irq(irq), .stable(stable)
  );

  function automatic int exp_div(input logic [2:0] c);
    case (c)
      3'b011:  return 1 << (TB + 1);
      3'b101:  return 1 << (TC + 1);
      3'b111:  return 1 << (TD + 1);
      default: return 1 << (TA + 1);
    endcase
  endfunction

  function automatic int exp_interval(input logic [2:0] c);
    return exp_div(c) * (1 << CW);
  endfunction

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic write_mode(input logic [3:0] v);
    @(negedge clk); mode_we = 1; mode_wdata = v;
    @(negedge clk); mode_we = 0;
  endtask

  task automatic write_bit(input logic v);
    @(negedge clk); bit_we = 1; bit_wdata = v;
    @(negedge clk); bit_we = 0;
  endtask

  task automatic pulse_clr;
    @(negedge clk); irq_clr = 1;
    @(negedge clk); irq_clr = 0;
  endtask

  task automatic wait_irq(input int lim, output int t);
    int k = 0;
    while (!irq && k < lim) begin @(negedge clk); k++; end
    t = cyc;
  endtask

  task automatic measure(input string tag, input int exp);
    int t1, t2;
    pulse_clr();
    wait_irq(3 * exp, t1);
    pulse_clr();
    wait_irq(3 * exp, t2);
    check((t2 - t1) == exp, tag, t2 - t1, exp);
  endtask

  task automatic do_reset;
    @(negedge clk); rst = 1;
    repeat (3) @(negedge clk);
  endtask

  task automatic boot_wait(input string tag);
    int t0, k;
    t0 = cyc; k = 0;
    while (!stable && k < 4000) begin @(negedge clk); k++; end
    check((cyc - t0) >= 15 * 64 && (cyc - t0) <= 16 * 64 + 2, tag, cyc - t0, 16 * 64);
    check(irq == 1, {tag, " irq at wrap"}, irq, 1);
  endtask

  initial begin
    #(8 * 190000);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    logic [2:0] code;
    int c0;
    void'($urandom(32'd4242));

    // R1 reset state
    do_reset();
    check(cnt == 0, "R1 cnt", cnt, 0);
    check(irq == 0, "R1 irq", irq, 0);
    check(stable == 0, "R1 stable", stable, 0);
    rst = 0;
    boot_wait("R9 boot wait");
    measure("R1 default rate", exp_interval(3'b000));

    // R9 boot ignores selection
    do_reset();
    rst = 0;
    repeat (5) @(negedge clk);
    mode_we = 1; mode_wdata = 4'b0111;
    @(negedge clk); mode_we = 0;
    boot_wait("R9 boot forced rate");
    measure("R9 rate after boot", exp_interval(3'b111));

    // R4 listed codes with restart, R2 restart clears
    foreach (code_list[i]) begin
      write_mode({1'b1, code_list[i]});
      check(cnt == 0 && irq == 0, "R2 restart via mode", {cnt, irq}, 0);
      measure($sformatf("R4 code %0b", code_list[i]), exp_interval(code_list[i]));
    end

    // R5 unlisted codes
    for (int i = 0; i < 2; i++) begin
      code = unl_list[$urandom_range(3, 0)];
      write_mode({1'b1, code});
      measure($sformatf("R5 code %0b", code), exp_interval(3'b000));
    end

    // R7 rate change keeps count
    write_mode(4'b1111);
    while (cnt != 5) @(negedge clk);
    write_mode(4'b0000);
    check(cnt == 5 || cnt == 6, "R7 count kept", cnt, 5);
    repeat (100) @(negedge clk);
    check(cnt != 0, "R7 count not reset", cnt, 5);
    measure("R7 new rate in force", exp_interval(3'b000));

    // R2 single-bit writes; R6 hold
    write_mode(4'b1111);
    measure("R4 fast rate", exp_interval(3'b111));
    repeat (40) @(negedge clk);
    check(irq == 1, "R6 irq held", irq, 1);
    while (cnt != 9) @(negedge clk);
    write_bit(1'b0);
    check(cnt == 9 || cnt == 10, "R2 bit write 0 no clear", cnt, 9);
    check(irq == 1, "R2 bit write 0 irq kept", irq, 1);
    write_bit(1'b1);
    check(cnt == 0 && irq == 0, "R2 bit write 1 restart", {cnt, irq}, 0);
    repeat (13) @(negedge clk);
    check(cnt != 0, "R2 restart self-clears", cnt, 3);
    while (cnt != 9) @(negedge clk);
    write_mode(4'b0111);
    check(cnt == 9 || cnt == 10, "R2 mode bit3=0 no restart", cnt, 9);
    wait_irq(200, c0);
    pulse_clr();
    check(irq == 0, "R6 irq_clr", irq, 1);

    // R10 restart at random phases
    for (int i = 0; i < 16; i++) begin
      repeat ($urandom_range(7, 0)) @(negedge clk);
      write_mode(4'b1111);
      check(cnt == 0, "R10 restart beats tick", cnt, 0);
    end

    // R3 counter always advances
    for (int i = 0; i < 10; i++) begin
      code = 3'($urandom_range(7, 0));
      write_mode({1'b0, code});
      c0 = cnt;
      repeat (2 * exp_div(code) + 1) @(negedge clk);
      check(cnt != c0, $sformatf("R3 advances code %0b", code), cnt, c0 + 2);
    end

    // R8 stop enter / release
    write_mode(4'b1101);
    @(negedge clk); stop_enter = 1;
    @(negedge clk); stop_enter = 0;
    check(stable == 0, "R8 stop_enter drops stable", stable, 0);
    pulse_clr();
    repeat (20) @(negedge clk);
    @(negedge clk); stop_release = 1;
    @(negedge clk); stop_release = 0;
    check(cnt == 0 && stable == 0, "R8 release clears", {cnt, stable}, 0);
    begin
      int t0, k;
      t0 = cyc; k = 0;
      while (!stable && k < 2000) begin @(negedge clk); k++; end
      check((cyc - t0) >= 15 * 16 && (cyc - t0) <= 16 * 16 + 2, "R8 wake wait",
            cyc - t0, 16 * 16);
      check(irq == 1, "R8 irq with stable", irq, 1);
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  logic [2:0] code_list [4] = '{3'b000, 3'b011, 3'b101, 3'b111};
  logic [2:0] unl_list  [4] = '{3'b001, 3'b010, 3'b100, 3'b110};
endmodule